// File: doc/BRIEF.md
# Clock-Data-Strobe Serial Transmitter

This block sends a parallel word over a three-wire link made of serial data, a shift clock and a strobe. It feeds a chain of `NUM_DEV` eight-bit shift registers with latched outputs. For every bit the block first places the bit on the data wire. It then drives the shift clock high and brings it back low. When the whole word has been shifted, it sends a single strobe pulse, and every device in the chain copies its shift stages to its outputs at the same moment.

A request pulse starts a frame. The word and a per-phase cycle count are captured in that same cycle. The bit shifted first ends up in the stage farthest along the chain, so the word is sent most significant bit first. Once the frame has been strobed, the word sits in the chain unchanged, with word bit 0 in the first stage of the nearest device. Each link phase lasts the same programmable number of system clock cycles. These phases are data setup, clock high, clock low, strobe high and strobe low.

Top module: `cds_serial_tx`

## Requirements
- R1: After reset, `busy`, `done`, `serClk`, `serStrobe` and `serData` are all 0.
- R2: A frame shifts all `8*NUM_DEV` bits of `word`, starting with bit `8*NUM_DEV-1` and ending with bit 0. After the strobe, a model chain that shifts toward higher bit positions on each shift-clock rise holds exactly `word`.
- R3: `serData` holds its value in the cycle the shift clock rises, in every cycle the shift clock is high, and in the cycle after it falls.
- R4: Every phase lasts `phaseLen` cycles, with 0 treated as 1. A whole frame keeps `busy` high for (3·`8*NUM_DEV`+2)·`phaseLen` cycles.
- R5: Exactly one strobe pulse is sent per frame, and only after the last bit has been clocked. The strobe and the shift clock are never high together.
- R6: A `start` seen while `busy` is high is ignored. It does not alter the bits in flight and does not start another frame.
- R7: `done` is a one-cycle pulse in the first cycle after the strobe-low phase ends. `busy` is already low in that cycle.
- R8: While idle, `serData` keeps the last bit sent (word bit 0).
- R9: While `busy` is low, `serClk` and `serStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send a frame, taken only when idle |
| phaseLen | input | CNT_W | System cycles per link phase, 0 acts as 1 |
| word | input | 8*NUM_DEV | Word to send, most significant bit first |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| serData | output | 1 | Serial data wire |
| serClk | output | 1 | Shift clock wire |
| serStrobe | output | 1 | Output-latch strobe wire |

## Verification
The bench models the receiving chain and checks that its content at the strobe equals the sent word. A reversed bit order, an extra or missing shift, or an early strobe would each leave the wrong value in the chain or trip the empty-queue check. Phase lengths of 0, 1, 3 and 5 are used, so an off-by-one in the phase counter shows up as a wrong clock-high run or a wrong frame length. A second `start` is injected in the middle of a frame. A design that restarts or reloads there would send the wrong bits or more than one strobe. The idle data level is checked after each frame, which catches a design that clears the data wire.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLKHI,
    ST_CLKLO,
    ST_STBHI,
    ST_STBLO
  } linkState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;    // capture word, present first bit
    logic shift;   // present next bit
    logic clkSet;
    logic clkClr;
    logic stbSet;
    logic stbClr;
  } ctlStrobes_t;
endpackage

// File: rtl/cds_ctrl.sv
module cds_ctrl
  import cds_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] phaseLen,
  output ctlStrobes_t      strb,
  output logic             busy,
  output logic             done
);
  localparam int BIT_W = $clog2(WORD_W);

  linkState_t       state, nextState;
  logic [CNT_W-1:0] phCnt, lenReg, effLen;
  logic [BIT_W-1:0] bitCnt;
  logic             phaseEnd;

  assign effLen   = (phaseLen == '0) ? CNT_W'(1) : phaseLen;
  assign phaseEnd = (phCnt == '0);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        nextState = ST_SETUP;
      end
      ST_SETUP: if (phaseEnd) begin
        strb.clkSet = 1'b1;
        nextState   = ST_CLKHI;
      end
      ST_CLKHI: if (phaseEnd) begin
        strb.clkClr = 1'b1;
        nextState   = ST_CLKLO;
      end
      ST_CLKLO: if (phaseEnd) begin
        if (bitCnt == '0) begin
          strb.stbSet = 1'b1;
          nextState   = ST_STBHI;
        end else begin
          strb.shift = 1'b1;
          nextState  = ST_SETUP;
        end
      end
      ST_STBHI: if (phaseEnd) begin
        strb.stbClr = 1'b1;
        nextState   = ST_STBLO;
      end
      ST_STBLO: if (phaseEnd) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phCnt  <= '0;
      lenReg <= CNT_W'(1);
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_STBLO) && phaseEnd;
      if (strb.load) begin
        lenReg <= effLen;
        bitCnt <= BIT_W'(WORD_W - 1);
        phCnt  <= effLen - CNT_W'(1);
      end else if (state != nextState) begin
        phCnt <= lenReg - CNT_W'(1);
      end else if (!phaseEnd) begin
        phCnt <= phCnt - CNT_W'(1);
      end
      if (strb.shift) bitCnt <= bitCnt - BIT_W'(1);
    end
  end
endmodule

// File: rtl/cds_datapath.sv
module cds_datapath
  import cds_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [WORD_W-1:0] word,
  output logic              serData,
  output logic              serClk,
  output logic              serStrobe
);
  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      serData   <= 1'b0;
      serClk    <= 1'b0;
      serStrobe <= 1'b0;
    end else begin
      if (strb.load) begin
        serData <= word[WORD_W-1];
        shReg   <= {word[WORD_W-2:0], 1'b0};
      end else if (strb.shift) begin
        serData <= shReg[WORD_W-1];
        shReg   <= {shReg[WORD_W-2:0], 1'b0};
      end
      if (strb.clkSet)      serClk <= 1'b1;
      else if (strb.clkClr) serClk <= 1'b0;
      if (strb.stbSet)      serStrobe <= 1'b1;
      else if (strb.stbClr) serStrobe <= 1'b0;
    end
  end
endmodule

// File: rtl/cds_serial_tx.sv
module cds_serial_tx
  import cds_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int CNT_W   = 8,
  localparam int WORD_W = 8 * NUM_DEV
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  phaseLen,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              done,
  output logic              serData,
  output logic              serClk,
  output logic              serStrobe
);
  ctlStrobes_t strb;

  cds_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .phaseLen(phaseLen),
    .strb(strb), .busy(busy), .done(done)
  );

  cds_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .word(word),
    .serData(serData), .serClk(serClk), .serStrobe(serStrobe)
  );
endmodule

// File: rtl/cds_serial_tx_chk.sv
module cds_serial_tx_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic serData,
  input logic serClk,
  input logic serStrobe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serClk && !serStrobe));

  // R3: data steady around and during clock high
  p_data_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (serClk || $past(serClk)) |-> $stable(serData));

  p_clk_stb_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(serClk && serStrobe));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && $past(!serStrobe)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(serData));

  p_idle_wires_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(serClk) && $stable(serStrobe)));
endmodule

bind cds_serial_tx cds_serial_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .serData(serData), .serClk(serClk), .serStrobe(serStrobe)
);

// File: tb/cds_serial_tx_bench.sv
module cds_serial_tx_bench;
  localparam int NUM_DEV = 2;
  localparam int CNT_W   = 8;
  localparam int W       = 8 * NUM_DEV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] phaseLen = '0;
  logic [W-1:0] word = '0;
  logic busy, done, serData, serClk, serStrobe;

  int nTests = 0;
  int nFail  = 0;

  bit       bitQ[$];
  logic [W-1:0] wordQ[$];
  int       lenQ[$];

  always #4 clk = ~clk;

  cds_serial_tx #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u_cds_serial_tx (
    .clk(clk), .rstN(rstN), .start(start), .phaseLen(phaseLen), .word(word),
    .busy(busy), .done(done), .serData(serData), .serClk(serClk),
    .serStrobe(serStrobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: pushes expectations and requests a frame
  task automatic sendFrame(input logic [W-1:0] w, input int len, input bit poke);
    while (busy) @(negedge clk);
    for (int i = W - 1; i >= 0; i--) bitQ.push_back(w[i]);
    wordQ.push_back(w);
    lenQ.push_back(len == 0 ? 1 : len);
    start = 1'b1; word = w; phaseLen = CNT_W'(len);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1; word = ~w; phaseLen = CNT_W'(1);   // R6: must be ignored
      @(negedge clk);
      start = 1'b0; word = '0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    // R8 / R9: idle level after the frame
    repeat (3) @(negedge clk);
    check(serData == w[0], "R8 idle data", int'(serData), int'(w[0]));
    check(!serClk && !serStrobe && !busy, "R9 idle wires", int'({busy, serClk, serStrobe}), 0);
  endtask

  // Monitor
  initial begin
    logic [W-1:0] chain = '0;
    logic [W-1:0] expW;
    bit prevClk = 0, prevStb = 0, prevBusy = 0, prevData = 0;
    int busyCnt = 0, hiCnt = 0, stbCnt = 0, curLen = 1;
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        if (busy && !prevBusy) begin
          curLen = (lenQ.size() > 0) ? lenQ.pop_front() : 1;
          busyCnt = 0; stbCnt = 0;
        end
        if (busy) busyCnt++;
        if (serClk && !prevClk) begin
          if (bitQ.size() == 0) check(0, "R2 unexpected shift", 1, 0);
          else begin
            bit e;
            e = bitQ.pop_front();
            check(serData == e, "R2 bit value", int'(serData), int'(e));
          end
          chain = {chain[W-2:0], serData};
          hiCnt = 0;
        end
        if (serClk) begin
          hiCnt++;
          if (prevClk && serData != prevData) check(0, "R3 data moved while clock high", 1, 0);
        end
        if (!serClk && prevClk) check(hiCnt == curLen, "R4 clock high length", hiCnt, curLen);
        if (serStrobe && !prevStb) begin
          stbCnt++;
          check(bitQ.size() == 0, "R5 strobe before last bit", bitQ.size(), 0);
          expW = (wordQ.size() > 0) ? wordQ.pop_front() : '0;
          check(chain == expW, "R2 chain content", int'(chain), int'(expW));
        end
        if (done) begin
          check(!busy, "R7 busy low with done", int'(busy), 0);
          check(stbCnt == 1, "R5 R6 strobes per frame", stbCnt, 1);
          check(busyCnt == (3 * W + 2) * curLen, "R4 frame length", busyCnt, (3 * W + 2) * curLen);
        end
        prevClk = serClk; prevStb = serStrobe; prevBusy = busy; prevData = serData;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, serClk, serStrobe, serData} == 5'b0, "R1 reset state",
          int'({busy, done, serClk, serStrobe, serData}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, serClk, serStrobe} == 4'b0, "R1 after release",
          int'({busy, done, serClk, serStrobe}), 0);
    sendFrame(16'hF00F, 1, 0);
    sendFrame(16'hA5C3, 3, 0);
    sendFrame(16'h0001, 0, 0);   // R4: zero acts as one
    sendFrame(16'h8000, 5, 1);   // R6: start poked mid-frame
    sendFrame(16'h3CF1, 2, 1);
    repeat (5) @(negedge clk);
    check(bitQ.size() == 0, "R2 leftover bits", bitQ.size(), 0);
    summary();
  end
endmodule